// File: doc/BRIEF.md
# Entropy CRC Accumulator with Read Interlock

This block conditions raw noise for a true random number generator. Three single-bit noise inputs, each coming from a free-running jittered oscillator, are gated by per-source enables. The surviving bits are XOR-folded into one bit, and that bit is shifted every clock into a 64-bit CRC register. Software reads the CRC register as its random word.

A control register holds the source enables, a mode bit, a minimum spacing between reads and an oscillator tuning code for each source. All sources share the one register, so the tuning codes are loaded one source at a time. A write that enables exactly one source stores the code field into that source's tuning register. Any other write leaves the stored codes alone. The codes go out to the oscillators on a dedicated output.

In normal mode, a read interlock holds the data port's ready low until the programmed number of cycles has passed since the last accepted read. This gives the CRC time to gather fresh entropy. In diagnostic mode, reads are never stalled.

Top module: `ent_crc_rng`

## Requirements
- R1: While reset is asserted and after it is released, the CRC register reads zero, the interlock counter is zero, every control field and tuning code is zero, and the data port's ready is high.
- R2: On each clock, the CRC register shifts left by one. The new bit is XORed with the old bit 63 to form a feedback bit. When the feedback bit is 1, the low 64 coefficients of x^64+x^61+x^57+x^56+x^52+x^51+x^50+x^48+x^47+x^46+x^43+x^42+x^41+x^39+x^38+x^37+x^35+x^32+x^28+x^25+x^22+x^21+x^17+x^15+x^13+x^12+x^11+x^7+x^5+x+1 are XORed into the shifted value.
- R3: The bit shifted in is the XOR of the noise inputs whose enable is set. A noise input whose enable is clear has no effect on the CRC.
- R4: With all three enables clear, a zero is shifted in every cycle, so a zero CRC stays zero whatever the noise inputs do.
- R5: The control word is laid out as follows. Bits [2:0] are the enables, with bit i for noise input i. Bit 3 is the mode, where 1 means normal and 0 means diagnostic. Bits [7:4] are the tuning code. Bits [23:8] are the read wait. A write takes effect on the next cycle, and the control read port returns the enables, mode and wait with the code field reading zero.
- R6: A control write with exactly one enable bit set stores bits [7:4] into that source's tuning code. Source i drives tuning output bits [4i+3:4i].
- R7: A control write with zero, two or three enable bits set updates the enables, mode and wait, but leaves all three tuning codes unchanged.
- R8: In normal mode with wait W, ready goes low for exactly W cycles after each accepted read, and then stays high until the next accepted read.
- R9: In diagnostic mode, the data port's ready is always high.
- R10: A read is accepted on a clock edge where valid and ready are both high. The data returned is the CRC value held during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| noise_i | input | 3 | Raw noise bits, one per source |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 24 | Control write data |
| ctl_rdata_o | output | 24 | Control register readback |
| vco_code_o | output | 12 | Tuning codes, 4 bits per source |
| rd_valid_i | input | 1 | Data read request |
| rd_ready_o | output | 1 | Data read may complete |
| rd_data_o | output | 64 | Random word |

## Verification
The assertions take it that a read request stays up once raised until it is accepted. They also take it that no control write lands in the same cycle as an accepted read when spacing is being checked, because such a write would legally change the wait under the interlock. The stimulus follows this. Control writes are issued only in stretches where the read request is idle or held steady. The noise inputs take fresh random values every cycle, so enabled and disabled sources are both exercised with activity on their pins.

// File: rtl/ent_crc_pkg.sv
package ent_crc_pkg;
  localparam int CRC_W  = 64;
  localparam int SRC_N  = 3;
  localparam int VCO_W  = 4;
  localparam int WAIT_W = 16;

  // low 64 coefficients of the conditioning polynomial (x^64 implied)
  localparam logic [CRC_W-1:0] CRC_TAPS =
      (64'd1 << 61) | (64'd1 << 57) | (64'd1 << 56) | (64'd1 << 52) |
      (64'd1 << 51) | (64'd1 << 50) | (64'd1 << 48) | (64'd1 << 47) |
      (64'd1 << 46) | (64'd1 << 43) | (64'd1 << 42) | (64'd1 << 41) |
      (64'd1 << 39) | (64'd1 << 38) | (64'd1 << 37) | (64'd1 << 35) |
      (64'd1 << 32) | (64'd1 << 28) | (64'd1 << 25) | (64'd1 << 22) |
      (64'd1 << 21) | (64'd1 << 17) | (64'd1 << 15) | (64'd1 << 13) |
      (64'd1 << 12) | (64'd1 << 11) | (64'd1 << 7)  | (64'd1 << 5)  |
      (64'd1 << 1)  | 64'd1;

  typedef enum logic {
    MODE_DIAG   = 1'b0,
    MODE_NORMAL = 1'b1
  } rng_mode_e;
endpackage

// File: rtl/ent_src_mix.sv
module ent_src_mix #(
  parameter int SRC_N = ent_crc_pkg::SRC_N
) (
  input  logic [SRC_N-1:0] noise_i,
  input  logic [SRC_N-1:0] en_i,
  output logic             mix_o
);
  logic [SRC_N-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_gate
      assign gated[g] = noise_i[g] & en_i[g];
    end
  endgenerate

  assign mix_o = ^gated;
endmodule

// File: rtl/ent_crc_shift.sv
module ent_crc_shift #(
  parameter int               CRC_W = ent_crc_pkg::CRC_W,
  parameter logic [CRC_W-1:0] TAPS  = ent_crc_pkg::CRC_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ din_i;
    crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & TAPS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ent_ctl_regs.sv
module ent_ctl_regs #(
  parameter int SRC_N  = ent_crc_pkg::SRC_N,
  parameter int VCO_W  = ent_crc_pkg::VCO_W,
  parameter int WAIT_W = ent_crc_pkg::WAIT_W,
  localparam int MODE_BIT = SRC_N,
  localparam int CODE_LSB = SRC_N + 1,
  localparam int WAIT_LSB = CODE_LSB + VCO_W,
  localparam int CTL_W    = WAIT_LSB + WAIT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [CTL_W-1:0]        wdata_i,
  output logic [SRC_N-1:0]        en_o,
  output ent_crc_pkg::rng_mode_e  mode_o,
  output logic [WAIT_W-1:0]       wait_o,
  output logic [SRC_N*VCO_W-1:0]  codes_o
);
  import ent_crc_pkg::*;

  logic [SRC_N-1:0]  w_en;
  logic [VCO_W-1:0]  w_code;
  logic [WAIT_W-1:0] w_wait;
  logic              w_single;

  logic [SRC_N-1:0]  en_q,   en_d;
  rng_mode_e         mode_q, mode_d;
  logic [WAIT_W-1:0] wait_q, wait_d;

  assign w_en     = wdata_i[SRC_N-1:0];
  assign w_code   = wdata_i[CODE_LSB +: VCO_W];
  assign w_wait   = wdata_i[WAIT_LSB +: WAIT_W];
  assign w_single = (w_en != '0) && ((w_en & (w_en - 1'b1)) == '0);

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    wait_d = wait_q;
    if (we_i) begin
      en_d   = w_en;
      mode_d = rng_mode_e'(wdata_i[MODE_BIT]);
      wait_d = w_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= MODE_DIAG;
      wait_q <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      wait_q <= wait_d;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SRC_N; s++) begin : g_code
      logic             ld;
      logic [VCO_W-1:0] code_q;
      logic [VCO_W-1:0] code_d;

      always_comb begin
        ld     = we_i && w_single && w_en[s];
        code_d = ld ? w_code : code_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
      end

      assign codes_o[s*VCO_W +: VCO_W] = code_q;
    end
  endgenerate

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign wait_o = wait_q;
endmodule

// File: rtl/ent_read_gate.sv
module ent_read_gate #(
  parameter int WAIT_W = ent_crc_pkg::WAIT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ent_crc_pkg::rng_mode_e mode_i,
  input  logic [WAIT_W-1:0]      wait_i,
  input  logic                   valid_i,
  output logic                   ready_o
);
  import ent_crc_pkg::*;

  localparam logic [WAIT_W-1:0] CNT_MAX = '1;

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              ready;
  logic              accept;

  always_comb begin
    ready  = (mode_i == MODE_DIAG) || (cnt_q >= wait_i);
    accept = valid_i && ready;
    if (accept)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;
    else                        cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = ready;
endmodule

// File: rtl/ent_crc_rng.sv
module ent_crc_rng #(
  parameter int SRC_N  = ent_crc_pkg::SRC_N,
  parameter int VCO_W  = ent_crc_pkg::VCO_W,
  parameter int WAIT_W = ent_crc_pkg::WAIT_W,
  localparam int CRC_W    = ent_crc_pkg::CRC_W,
  localparam int CODE_LSB = SRC_N + 1,
  localparam int WAIT_LSB = CODE_LSB + VCO_W,
  localparam int CTL_W    = WAIT_LSB + WAIT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_N-1:0]       noise_i,
  input  logic                   ctl_we_i,
  input  logic [CTL_W-1:0]       ctl_wdata_i,
  output logic [CTL_W-1:0]       ctl_rdata_o,
  output logic [SRC_N*VCO_W-1:0] vco_code_o,
  input  logic                   rd_valid_i,
  output logic                   rd_ready_o,
  output logic [CRC_W-1:0]       rd_data_o
);
  import ent_crc_pkg::*;

  logic [SRC_N-1:0]  en_q;
  rng_mode_e         mode_q;
  logic [WAIT_W-1:0] wait_q;
  logic              mix_bit;
  logic [CRC_W-1:0]  crc_q;

  ent_ctl_regs #(.SRC_N(SRC_N), .VCO_W(VCO_W), .WAIT_W(WAIT_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .en_o    (en_q),
    .mode_o  (mode_q),
    .wait_o  (wait_q),
    .codes_o (vco_code_o)
  );

  ent_src_mix #(.SRC_N(SRC_N)) u_mix (
    .noise_i (noise_i),
    .en_i    (en_q),
    .mix_o   (mix_bit)
  );

  ent_crc_shift u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (mix_bit),
    .crc_o (crc_q)
  );

  ent_read_gate #(.WAIT_W(WAIT_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_q),
    .wait_i  (wait_q),
    .valid_i (rd_valid_i),
    .ready_o (rd_ready_o)
  );

  assign ctl_rdata_o = {wait_q, {VCO_W{1'b0}}, logic'(mode_q), en_q};
  assign rd_data_o   = crc_q;
endmodule

// File: rtl/ent_crc_rng_chk.sv
module ent_crc_rng_chk #(
  parameter int SRC_N  = 3,
  parameter int VCO_W  = 4,
  parameter int WAIT_W = 16,
  parameter int CTL_W  = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic                   mode,
  input logic [WAIT_W-1:0]      wait_v,
  input logic [SRC_N-1:0]       en,
  input logic                   mix,
  input logic [63:0]            crc,
  input logic                   ctl_we,
  input logic [CTL_W-1:0]       ctl_wdata,
  input logic [SRC_N*VCO_W-1:0] codes
);
  assert_diag_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> rd_ready);

  assert_stall_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && mode && wait_v != '0 && !ctl_we) |=> !rd_ready);

  assert_hold_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && rd_ready && !rd_valid && !ctl_we) |=> rd_ready);

  assert_zero_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0 && crc == 64'd0) |=> crc == 64'd0);

  assert_plain_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc[63] && !mix) |=> crc == {$past(crc[62:0]), 1'b0});

  assert_codes_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && $countones(ctl_wdata[SRC_N-1:0]) != 1) |=> $stable(codes));
endmodule

bind ent_crc_rng ent_crc_rng_chk #(
  .SRC_N(SRC_N), .VCO_W(VCO_W), .WAIT_W(WAIT_W), .CTL_W(CTL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid_i),
  .rd_ready  (rd_ready_o),
  .mode      (mode_q),
  .wait_v    (wait_q),
  .en        (en_q),
  .mix       (mix_bit),
  .crc       (crc_q),
  .ctl_we    (ctl_we_i),
  .ctl_wdata (ctl_wdata_i),
  .codes     (vco_code_o)
);

// File: tb/test_ent_crc_rng.sv
module test_ent_crc_rng;
  logic        clk;
  logic        rst_n;
  logic [2:0]  noise;
  logic        ctl_we;
  logic [23:0] ctl_wdata;
  logic [23:0] ctl_rdata;
  logic [11:0] vco_code;
  logic        rd_valid;
  logic        rd_ready;
  logic [63:0] rd_data;

  ent_crc_rng i_ent_crc_rng (
    .clk(clk), .rst_n(rst_n), .noise_i(noise),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .vco_code_o(vco_code), .rd_valid_i(rd_valid), .rd_ready_o(rd_ready),
    .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  logic [63:0] m_crc;
  int          m_cnt;
  int          m_en, m_mode, m_wait;
  int          m_code[3];
  int          taps[$] = '{61,57,56,52,51,50,48,47,46,43,42,41,39,38,37,35,
                            32,28,25,22,21,17,15,13,12,11,7,5,1,0};

  function automatic bit m_ready();
    return (m_mode == 0) || (m_cnt >= m_wait);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_crc = '0; m_cnt = 0; m_en = 0; m_mode = 0; m_wait = 0;
      foreach (m_code[i]) m_code[i] = 0;
    end else begin
      int  din;
      bit  fb;
      bit  acc;
      int  ones;
      acc = rd_valid && m_ready();
      din = 0;
      for (int i = 0; i < 3; i++) if (m_en[i]) din = din ^ noise[i];
      fb = m_crc[63] ^ din[0];
      m_crc = m_crc << 1;
      if (fb) foreach (taps[k]) m_crc[taps[k]] = ~m_crc[taps[k]];
      if (acc) m_cnt = 0;
      else if (m_cnt < 65535) m_cnt++;
      if (ctl_we) begin
        ones = 0;
        for (int i = 0; i < 3; i++) ones += ctl_wdata[i];
        if (ones == 1)
          for (int i = 0; i < 3; i++) if (ctl_wdata[i]) m_code[i] = ctl_wdata[7:4];
        m_en   = ctl_wdata[2:0];
        m_mode = ctl_wdata[3];
        m_wait = ctl_wdata[23:8];
      end
    end
  end

  // per-cycle comparison and noise stimulus, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_data == m_crc, "R2/R3/R10 crc", rd_data, m_crc);
      check(rd_ready == m_ready(), "R8/R9 ready", 64'(rd_ready), 64'(m_ready()));
      check(vco_code == {m_code[2][3:0], m_code[1][3:0], m_code[0][3:0]},
            "R6/R7 codes", 64'(vco_code),
            64'({m_code[2][3:0], m_code[1][3:0], m_code[0][3:0]}));
    end
    noise = 3'($urandom);
  end

  task automatic ctl_write(int en, int mode, int code, int wt);
    ctl_wdata = {wt[15:0], code[3:0], mode[0], en[2:0]};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; rd_valid = 1'b0; noise = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_data == 64'd0, "R1 crc", rd_data, 0);
    check(rd_ready == 1'b1, "R1 ready", 64'(rd_ready), 1);
    check(ctl_rdata == 24'd0, "R1 ctl", 64'(ctl_rdata), 0);
    check(vco_code == 12'd0, "R1 codes", 64'(vco_code), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R4 all sources off: CRC stays zero
    check(rd_data == 64'd0, "R4 zero shifting", rd_data, 0);

    // R6 per-source tuning loads
    ctl_write(1, 0, 5, 0);
    ctl_write(2, 0, 9, 0);
    ctl_write(4, 0, 12, 0);
    check(vco_code == 12'hC95, "R6 codes", 64'(vco_code), 64'hC95);
    // R7 multi and zero enable writes keep codes
    ctl_write(7, 0, 3, 7);
    check(vco_code == 12'hC95, "R7 codes multi", 64'(vco_code), 64'hC95);
    check(ctl_rdata == 24'h000707, "R5 readback", 64'(ctl_rdata), 64'h000707);
    ctl_write(0, 1, 15, 2);
    check(vco_code == 12'hC95, "R7 codes zero", 64'(vco_code), 64'hC95);
    check(ctl_rdata == 24'h000208, "R5 readback2", 64'(ctl_rdata), 64'h000208);

    // R9 diagnostic mode, all sources, random reads
    ctl_write(7, 0, 0, 40);
    for (int i = 0; i < 200; i++) begin
      rd_valid = 1'($urandom);
      @(negedge clk);
      check(rd_ready == 1'b1, "R9 diag ready", 64'(rd_ready), 1);
    end
    rd_valid = 1'b0;

    // R3 subsets of sources
    ctl_write(5, 0, 0, 0);
    repeat (100) @(negedge clk);
    ctl_write(2, 0, 6, 0);
    repeat (100) @(negedge clk);

    // R8 normal mode spacing for several waits including boundaries
    foreach (taps[w]) begin end
    for (int pass = 0; pass < 4; pass++) begin
      int wt;
      wt = (pass == 0) ? 0 : (pass == 1) ? 1 : (pass == 2) ? 10 : 37;
      ctl_write(7, 1, 0, wt);
      repeat (wt + 2) @(negedge clk);
      rd_valid = 1'b1;
      // wait for first acceptance opportunity
      while (!rd_ready) @(negedge clk);
      @(negedge clk);
      for (int r = 0; r < 4; r++) begin
        int low;
        low = 0;
        while (!rd_ready && low < 1000) begin
          low++;
          @(negedge clk);
        end
        check(low == wt, "R8 stall length", 64'(low), 64'(wt));
        @(negedge clk);
      end
      rd_valid = 1'b0;
      repeat (wt + 3) @(negedge clk);
      check(rd_ready == 1'b1, "R8 idle ready", 64'(rd_ready), 1);
    end

    // R10 random reads in normal mode against the model
    ctl_write(7, 1, 0, 5);
    for (int i = 0; i < 300; i++) begin
      if (!rd_valid || rd_ready) rd_valid = 1'($urandom);
      @(negedge clk);
    end
    rd_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule